// File: doc/BRIEF.md
# Mixed Latched and Level Interrupt Status Unit

This block gathers five interrupt sources from an analog conversion and supply-monitor subsystem into one status word. Three sources are sticky: the brown-out alarm, the pen-touch event and the end-of-conversion-sequence event. Each arrives as a single-cycle pulse, and its status bit stays set until software writes a 1 to the matching bit of the clear register. The other two sources come from the sample FIFO and clear themselves. One is the watermark condition, where the fill level is above a programmable threshold. The other is the overrun condition, where a push was attempted while the FIFO was full; it holds until the level drops below full.

Each raw status bit is gated by a per-source enable bit. The gated result is the masked status word, which software reads at a read-only offset. A registered interrupt line carries the OR of all masked bits. Register access uses a plain write strobe, an address and a write word. Read data is combinational on the address and has no handshake. The FIFO fill level and the push-attempt flag are plain status inputs, sampled on every clock. Nothing here flows as a stream, so no pin uses valid/ready.

Register map, as byte offsets: 0x00 masked status (read-only), 0x04 raw status (read-only), 0x08 enable mask (read/write), 0x0C clear (write-only, reads 0), 0x10 watermark level (read/write). Status, enable and clear share one bit layout: bit 4 brown-out, bit 3 pen, bit 2 end of sequence, bit 1 FIFO watermark, bit 0 FIFO overrun.

Top module: `intr_status_unit`

## Requirements
- R1: After reset the following all read 0: masked status, raw status and the enable mask. The irq output is 0, and the watermark level reads its reset value of 8.
- R2: In the masked status word, bits 31 to 5 always read 0. Bits 4 down to 0 carry brown-out, pen, end of sequence, watermark and overrun, in that order.
- R3: A masked status bit reads 1 exactly when its raw bit is 1 and its enable bit is 1.
- R4: A pulse on a sticky source input sets its raw bit (bit 4, 3 or 2) at the next clock edge. The bit then holds until a clear write carries a 1 in that position.
- R5: If a sticky source pulses in the same cycle as a clear write to its bit, the bit ends up set.
- R6: A clear write has no effect on any bit written as 0, on bits 1 and 0, or on bits 31 to 5.
- R7: One cycle after the FIFO level is strictly greater than the watermark level, raw bit 1 reads 1. In any other case it reads 0 one cycle later.
- R8: Raw bit 0 becomes 1 one cycle after a push attempt while the level equals the FIFO depth of 16. It stays 1 while the level remains 16, and it returns to 0 one cycle after the level is below 16.
- R9: The enable mask is 5 bits wide and read/write at offset 0x08. Bits 31 to 5 read 0.
- R10: The irq output is a register. In each cycle it equals the OR of the masked status word from the cycle before.
- R11: The clear offset reads 0. Writes to the masked and raw status offsets change nothing.
- R12: The watermark level at offset 0x10 is read/write over the low 5 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_brownout | input | 1 | Brown-out event pulse |
| evt_pen | input | 1 | Pen-touch event pulse |
| evt_eos | input | 1 | End-of-sequence event pulse |
| fifo_level | input | 5 | Current FIFO fill count, 0 to 16 |
| fifo_push_try | input | 1 | A push to the FIFO is attempted this cycle |
| irq | output | 1 | Registered combined interrupt |

## Verification
The assertions assume three things about the inputs: fifo_level never exceeds the FIFO depth, event inputs are sampled once per clock, and reset lasts at least one edge. The overrun properties compare the level against the full value and read nothing above it. The stimulus draws the level only from 0 to 16 and weights it toward full, so overrun entry and exit are hit often. Event pulses, clear writes and enable writes are drawn independently, so set-versus-clear collisions occur both by chance and in a directed case.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int NUM_SRC     = 5;
  localparam int NUM_STICKY  = 3;

  // bit positions shared by status, enable and clear words
  localparam int BIT_FOVR = 0;
  localparam int BIT_FWM  = 1;
  localparam int BIT_EOS  = 2;
  localparam int BIT_PEN  = 3;
  localparam int BIT_BOD  = 4;

  // byte offsets
  localparam int OFS_MASKED = 'h00;
  localparam int OFS_RAW    = 'h04;
  localparam int OFS_ENABLE = 'h08;
  localparam int OFS_CLEAR  = 'h0C;
  localparam int OFS_LEVEL  = 'h10;

  typedef struct packed {
    logic enable;
    logic clear;
    logic level;
  } wr_hit_t;
endpackage

// File: rtl/isu_sticky_bank.sv
module isu_sticky_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_pulse,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] sticky_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)            q <= 1'b0;
      else if (set_pulse[i]) q <= 1'b1;
      else if (clr_req[i])   q <= 1'b0;
    end
    assign sticky_q[i] = q;

    // R5: a pulse always leaves the bit set, clear or not
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse[i] |=> sticky_q[i]);
    // R4: holds until cleared
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q[i] && !clr_req[i]) |=> sticky_q[i]);
    // R4: clear without pulse drops the bit
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[i] && !set_pulse[i]) |=> !sticky_q[i]);
    // R4: no spontaneous set
    a_r4_no_spont: assert property (@(posedge clk) disable iff (!rst_n)
      (!sticky_q[i] && !set_pulse[i]) |=> !sticky_q[i]);
  end
endmodule

// File: rtl/isu_fifo_cond.sv
module isu_fifo_cond #(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             fifo_push_try,
  input  logic [LVL_W-1:0] wm_level,
  output logic             wm_q,
  output logic             ovr_q
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  logic at_full;
  logic above_wm;

  assign at_full  = (fifo_level == FULL_LVL);
  assign above_wm = (fifo_level > wm_level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wm_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      wm_q  <= above_wm;
      ovr_q <= at_full && (ovr_q || fifo_push_try);
    end
  end

  // R7: watermark follows the comparison one cycle later
  a_r7_wm_on: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level > wm_level) |=> wm_q);
  a_r7_wm_off: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level <= wm_level) |=> !wm_q);
  // R8: overrun entry, hold, exit
  a_r8_ovr_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push_try && fifo_level == FULL_LVL) |=> ovr_q);
  a_r8_ovr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && fifo_level == FULL_LVL) |=> ovr_q);
  a_r8_ovr_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level != FULL_LVL) |=> !ovr_q);
endmodule

// File: rtl/isu_regfile.sv
module isu_regfile
  import isu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int LVL_W     = 5,
  parameter int WM_RESET  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  logic [NUM_SRC-1:0]    raw,
  output logic [NUM_SRC-1:0]    masked,
  output logic [NUM_STICKY-1:0] clr_req,
  output logic [LVL_W-1:0]      wm_level,
  output logic [DATA_W-1:0]     reg_rdata
);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_LEVEL  = ADDR_W'(OFS_LEVEL);

  logic [NUM_SRC-1:0] en_q;
  wr_hit_t            hit;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:NUM_SRC];

  assign hit.enable = reg_wr && (reg_addr == A_ENABLE);
  assign hit.clear  = reg_wr && (reg_addr == A_CLEAR);
  assign hit.level  = reg_wr && (reg_addr == A_LEVEL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      wm_level <= LVL_W'(WM_RESET);
    end else begin
      if (hit.enable) en_q     <= reg_wdata[NUM_SRC-1:0];
      if (hit.level)  wm_level <= reg_wdata[LVL_W-1:0];
    end
  end

  // only the sticky positions of a clear write reach the bank
  assign clr_req = hit.clear ? reg_wdata[BIT_BOD:BIT_EOS] : '0;

  assign masked = raw & en_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MASKED: reg_rdata[NUM_SRC-1:0] = masked;
      A_RAW:    reg_rdata[NUM_SRC-1:0] = raw;
      A_ENABLE: reg_rdata[NUM_SRC-1:0] = en_q;
      A_LEVEL:  reg_rdata[LVL_W-1:0]   = wm_level;
      default:  reg_rdata = '0;
    endcase
  end

  // R9: enable changes only on a write to its offset
  a_r9_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !hit.enable |=> $stable(en_q));
  a_r9_en_write: assert property (@(posedge clk) disable iff (!rst_n)
    hit.enable |=> (en_q == $past(reg_wdata[NUM_SRC-1:0])));
  // R2: reserved bits of masked word
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_MASKED) |-> (reg_rdata[DATA_W-1:NUM_SRC] == '0));
  // R3: masked never wider than raw
  a_r3_masked_subset: assert property (@(posedge clk) disable iff (!rst_n)
    ((masked & ~raw) == '0));
  // R11: clear offset reads zero
  a_r11_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CLEAR) |-> (reg_rdata == '0));
endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit
  import isu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int WM_RESET   = 8,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evt_brownout,
  input  logic              evt_pen,
  input  logic              evt_eos,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              fifo_push_try,
  output logic              irq
);
  logic [NUM_STICKY-1:0] sticky_q;
  logic [NUM_STICKY-1:0] clr_req;
  logic [NUM_SRC-1:0]    raw;
  logic [NUM_SRC-1:0]    masked;
  logic [LVL_W-1:0]      wm_level;
  logic                  wm_q;
  logic                  ovr_q;

  isu_sticky_bank #(.N(NUM_STICKY)) u_sticky (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse ({evt_brownout, evt_pen, evt_eos}),
    .clr_req   (clr_req),
    .sticky_q  (sticky_q)
  );

  isu_fifo_cond #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_level    (fifo_level),
    .fifo_push_try (fifo_push_try),
    .wm_level      (wm_level),
    .wm_q          (wm_q),
    .ovr_q         (ovr_q)
  );

  assign raw = {sticky_q, wm_q, ovr_q};

  isu_regfile #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .LVL_W    (LVL_W),
    .WM_RESET (WM_RESET)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .raw       (raw),
    .masked    (masked),
    .clr_req   (clr_req),
    .wm_level  (wm_level),
    .reg_rdata (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |masked;
  end

  // R10: irq follows the masked word one cycle late
  a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|masked) |=> irq);
  a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (masked == '0) |=> !irq);
endmodule

// File: tb/intr_status_unit_bench.sv
`timescale 1ns/1ps
module intr_status_unit_bench;
  localparam int DEPTH = 16;
  localparam int WMRST = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        evt_brownout = 1'b0, evt_pen = 1'b0, evt_eos = 1'b0;
  logic [4:0]  fifo_level = '0;
  logic        fifo_push_try = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  intr_status_unit u_intr_status_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_brownout(evt_brownout), .evt_pen(evt_pen), .evt_eos(evt_eos),
    .fifo_level(fifo_level), .fifo_push_try(fifo_push_try), .irq(irq)
  );

  // reference model built from the requirements
  logic [2:0] m_stk;   // {bod, pen, eos}
  logic       m_wm, m_ovr, m_irq;
  logic [4:0] m_en, m_wml;
  logic [4:0] m_raw;
  assign m_raw = {m_stk, m_wm, m_ovr};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stk <= '0; m_wm <= 1'b0; m_ovr <= 1'b0; m_irq <= 1'b0;
      m_en <= '0; m_wml <= 5'(WMRST);
    end else begin
      m_stk <= {evt_brownout, evt_pen, evt_eos} |
               (m_stk & ~((reg_wr && reg_addr == 8'h0C) ? reg_wdata[4:2] : 3'b000));
      m_wm  <= fifo_level > m_wml;
      m_ovr <= (fifo_level == 5'(DEPTH)) && (m_ovr || fifo_push_try);
      m_irq <= |(m_raw & m_en);
      if (reg_wr && reg_addr == 8'h08) m_en  <= reg_wdata[4:0];
      if (reg_wr && reg_addr == 8'h10) m_wml <= reg_wdata[4:0];
    end
  end

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00:   return {27'd0, m_raw & m_en};
      8'h04:   return {27'd0, m_raw};
      8'h08:   return {27'd0, m_en};
      8'h10:   return {27'd0, m_wml};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00:   return "R3";
      8'h04:   return "R4";
      8'h08:   return "R9";
      8'h0C:   return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle at negedge, check after the edge
  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                      input logic [2:0] ev, input logic [4:0] lvl, input logic push);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    {evt_brownout, evt_pen, evt_eos} = ev;
    fifo_level = lvl; fifo_push_try = push;
    @(posedge clk);
    #2;
    chk(tag_of(a), reg_rdata, exp_read(a));
    chk("R10", {31'd0, irq}, {31'd0, m_irq});
  endtask

  // read without clocking state that the model misses
  task automatic peek(input logic [7:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a; evt_brownout = 0; evt_pen = 0; evt_eos = 0;
    fifo_push_try = 1'b0;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(8'h00, "R1", 32'd0);
    peek(8'h04, "R1", 32'd0);
    peek(8'h08, "R1", 32'd0);
    peek(8'h10, "R1", 32'd8);
    chk("R1", {31'd0, irq}, 32'd0);
    // R12 level register
    step(1, 8'h10, 32'hFFFF_FFE3, 3'b000, 5'd0, 0);
    peek(8'h10, "R12", 32'd3);
    // R9 enable width
    step(1, 8'h08, 32'hFFFF_FFFF, 3'b000, 5'd0, 0);
    peek(8'h08, "R9", 32'h1F);
    // R4 pen sets and holds
    step(0, 8'h04, 32'd0, 3'b010, 5'd0, 0);
    step(0, 8'h04, 32'd0, 3'b000, 5'd0, 0);
    peek(8'h04, "R4", 32'h08);
    // R5 set beats clear on end of sequence
    step(1, 8'h0C, 32'h04, 3'b001, 5'd0, 0);
    peek(8'h04, "R5", 32'h0C);
    // R7 watermark above level 3
    step(0, 8'h04, 32'd0, 3'b000, 5'd4, 0);
    peek(8'h04, "R7", 32'h0E);
    step(0, 8'h04, 32'd0, 3'b000, 5'd3, 0);
    peek(8'h04, "R7", 32'h0C);
    // R8 overrun sequence
    step(0, 8'h04, 32'd0, 3'b000, 5'd16, 0);
    peek(8'h04, "R8", 32'h0E);
    step(0, 8'h04, 32'd0, 3'b000, 5'd16, 1);
    peek(8'h04, "R8", 32'h0F);
    step(0, 8'h04, 32'd0, 3'b000, 5'd16, 0);
    peek(8'h04, "R8", 32'h0F);
    // R6 clear of low bits, zeros and upper bits touches nothing
    step(1, 8'h0C, 32'hFFFF_FFE3, 3'b000, 5'd16, 0);
    peek(8'h04, "R6", 32'h0F);
    // R2 masked word layout with everything enabled
    peek(8'h00, "R2", 32'h0F);
    // R11 writes to status offsets ignored, clear reads zero
    step(1, 8'h00, 32'h0, 3'b000, 5'd16, 0);
    step(1, 8'h04, 32'h0, 3'b000, 5'd16, 0);
    peek(8'h04, "R11", 32'h0F);
    peek(8'h0C, "R11", 32'h0);
    step(0, 8'h04, 32'd0, 3'b000, 5'd15, 0);
    peek(8'h04, "R8", 32'h0E);
    // R4 clear of pen only
    step(1, 8'h0C, 32'h08, 3'b000, 5'd0, 0);
    peek(8'h04, "R4", 32'h04);
    // R3 masked with partial enable
    step(1, 8'h08, 32'h03, 3'b000, 5'd0, 0);
    peek(8'h00, "R3", 32'h00);
    step(1, 8'h08, 32'h04, 3'b000, 5'd0, 0);
    peek(8'h00, "R3", 32'h04);

    // constrained random phase
    for (int k = 0; k < 4000; k++) begin
      logic [7:0]  a;
      logic [31:0] wd;
      logic [4:0]  lvl;
      logic        wr;
      case ($urandom_range(0, 4))
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C; default: a = 8'h10;
      endcase
      wr  = ($urandom_range(0, 5) == 0);
      wd  = $urandom();
      if (a == 8'h10) wd[4:0] = 5'($urandom_range(0, 16));
      lvl = ($urandom_range(0, 3) == 0) ? 5'd16 : 5'($urandom_range(0, 16));
      step(wr, a, wd,
           {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
            ($urandom_range(0, 7) == 0)},
           lvl, ($urandom_range(0, 3) == 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule